// File: doc/BRIEF.md
# Masked Vector Unsigned-to-Single Converter

This block turns up to sixteen 32-bit unsigned integers into IEEE-754 single-precision values, one lane per element, and registers the result. It can work on a quarter, a half or all of a 512-bit vector. Each lane can be written, kept from an earlier destination value, or cleared, under control of a per-lane mask. The mask can be switched off, and a merge/zero select chooses what happens to masked lanes.

A caller can broadcast element 0 of a memory operand to every lane. A per-operation rounding override is honoured only in one case: a full-length vector with a register source and the override bit set. In every other case a global rounding mode applies. Lanes above the selected length always come out as zero. A sticky flag records any conversion that lost precision. Only reset clears it.

An operation is presented as one cycle with `op_valid` high. Its result appears on `res_vec` after the next rising clock edge. The result then holds until the next operation.

Top module: `uint_vec_to_fp32`

## Requirements
- R1: While reset is asserted and after it is released, `res_vec` is all zero and `inexact` is 0 until the first operation.
- R2: An input of 0 converts to 0x00000000. Every input below 2^24 converts exactly, and an exact conversion never sets `inexact`.
- R3: Rounding mode codes are 0 for nearest-even, 1 toward negative infinity, 2 toward positive infinity and 3 toward zero. A carry out of the fraction raises the exponent. For example, 0xFFFFFFFF gives 0x4F800000 under codes 0 and 2, and 0x4F7FFFFF under codes 1 and 3.
- R4: Inputs are unsigned, so every converted lane has bit 31 equal to 0, including inputs with bit 31 set (0x80000000 gives 0x4F000000).
- R5: `emb_rm` is used only when `vlen_code` selects full length (2 or 3), `bcast_en` is 1 and `src_mem` is 0. Otherwise `glob_rm` is used.
- R6: With `bcast_en` and `src_mem` both 1, every active lane converts `src_vec[31:0]`.
- R7: `vlen_code` 0, 1, 2 and 3 activate the lower 4, 8, 16 and 16 lanes. Lane j is bits 32j+31 down to 32j.
- R8: All result bits above the active lanes are zero, whatever the mask and the destination value.
- R9: An active lane takes its converted value when `mask_en` is 0 or when its `lane_mask` bit is 1.
- R10: With `zero_mode` 0, an active lane whose mask bit is 0 (while `mask_en` is 1) takes the matching bits of `prev_dst`.
- R11: With `zero_mode` 1, an active lane whose mask bit is 0 (while `mask_en` is 1) is zero.
- R12: `inexact` becomes 1 after an operation in which an active, written lane discarded nonzero bits. Masked or inactive lanes never set it, and it stays 1 until reset.
- R13: `res_vec` and `inexact` change only on the clock edge that samples `op_valid` high, and they hold otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Capture the current operation |
| src_vec | input | 512 | Source integers, 32 bits per lane |
| vlen_code | input | 2 | Vector length select (0 quarter, 1 half, 2 or 3 full) |
| lane_mask | input | 16 | Per-lane write enables |
| mask_en | input | 1 | 1 applies `lane_mask`, 0 writes every active lane |
| zero_mode | input | 1 | Masked lanes: 1 clears them, 0 keeps `prev_dst` |
| bcast_en | input | 1 | Broadcast/override bit |
| src_mem | input | 1 | Source is a memory operand |
| emb_rm | input | 2 | Per-operation rounding mode |
| glob_rm | input | 2 | Global rounding mode |
| prev_dst | input | 512 | Earlier destination value for merging |
| res_vec | output | 512 | Registered result |
| inexact | output | 1 | Sticky precision-loss flag |

## Verification
Each lane is tried with four kinds of input:
- Zero and values below 2^24, which tell exact normalisation apart from rounding.
- Values just above 2^24 with ties and odd fractions, which separate nearest-even from the directed modes.
- All-ones and top-bit values, which expose a missing exponent carry and signed handling.
- Random full-range words.

Directed masks, broadcast settings and length codes separate merge from zero masking, and element 0 from a lane's own element. They also show where the override is chosen against the global mode. Resets interleaved through the sweep show whether masked or inactive lanes wrongly raise the sticky flag.

// File: rtl/u2f_pkg.sv
package u2f_pkg;
   localparam int ELEM_W   = 32;
   localparam int EXP_W    = 8;
   localparam int FRAC_W   = 23;
   localparam int EXP_BIAS = 127;
   localparam int CNT_W    = $clog2(ELEM_W);
   localparam int GUARD_IX = ELEM_W - FRAC_W - 2;

   typedef enum logic [1:0] {
      RND_NEAR_EVEN = 2'd0,
      RND_DOWN      = 2'd1,
      RND_UP        = 2'd2,
      RND_TRUNC     = 2'd3
   } rnd_mode_e;

   typedef enum logic [1:0] {
      VL_QUARTER  = 2'd0,
      VL_HALF     = 2'd1,
      VL_FULL     = 2'd2,
      VL_FULL_ALT = 2'd3
   } vlen_e;
endpackage

// File: rtl/u2f_lzc.sv
module u2f_lzc #(
   parameter  int W  = 32,
   localparam int CW = $clog2(W)
) (
   input  logic [W-1:0]  din,
   output logic [CW-1:0] cnt,
   output logic          all_zero
);
   if (W < 2) begin : g_bad_width
      $error("u2f_lzc: W must be at least 2");
   end

   // ascending scan: the highest set bit is the last to assign
   always_comb begin
      cnt      = '0;
      all_zero = 1'b1;
      for (int i = 0; i < W; i++) begin
         if (din[i]) begin
            cnt      = CW'(W - 1 - i);
            all_zero = 1'b0;
         end
      end
   end
endmodule

// File: rtl/u2f_lane_cvt.sv
module u2f_lane_cvt
   import u2f_pkg::*;
(
   input  logic [ELEM_W-1:0] ival,
   input  logic [1:0]        rmode,
   output logic [ELEM_W-1:0] fval,
   output logic              inexact
);
   logic [CNT_W-1:0]        lz;
   logic                    is_zero;
   logic [ELEM_W-1:0]       norm;
   logic [FRAC_W-1:0]       mant;
   logic [EXP_W-1:0]        expo;
   logic                    guard_b;
   logic                    sticky_b;
   logic                    round_up;
   logic [EXP_W+FRAC_W-1:0] packed_sum;

   u2f_lzc #(.W(ELEM_W)) i_lzc (
      .din      (ival),
      .cnt      (lz),
      .all_zero (is_zero)
   );

   // leading one lands on the top bit; the fraction and round bits follow it
   assign norm     = ival << lz;
   assign mant     = norm[ELEM_W-2 -: FRAC_W];
   assign guard_b  = norm[GUARD_IX];
   assign sticky_b = |norm[GUARD_IX-1:0];
   assign expo     = EXP_W'(EXP_BIAS + ELEM_W - 1) - EXP_W'(lz);

   always_comb begin
      unique case (rnd_mode_e'(rmode))
         RND_NEAR_EVEN: round_up = guard_b & (sticky_b | mant[0]);
         RND_UP:        round_up = guard_b | sticky_b;
         RND_DOWN:      round_up = 1'b0;
         RND_TRUNC:     round_up = 1'b0;
         default:       round_up = 1'b0;
      endcase
   end

   // a fraction overflow ripples into the exponent field
   assign packed_sum = {expo, mant} + (EXP_W+FRAC_W)'(round_up);
   assign fval       = is_zero ? '0 : {1'b0, packed_sum};
   assign inexact    = ~is_zero & (guard_b | sticky_b);
endmodule

// File: rtl/u2f_lane_sel.sv
module u2f_lane_sel
   import u2f_pkg::*;
(
   input  logic [ELEM_W-1:0] conv_val,
   input  logic [ELEM_W-1:0] prev_val,
   input  logic              lane_active,
   input  logic              mask_bit,
   input  logic              mask_en,
   input  logic              zero_mode,
   input  logic              conv_inx,
   output logic [ELEM_W-1:0] lane_nxt,
   output logic              lane_inx
);
   logic write_en;

   assign write_en = lane_active & (~mask_en | mask_bit);
   assign lane_inx = write_en & conv_inx;

   always_comb begin
      if (!lane_active)   lane_nxt = '0;
      else if (write_en)  lane_nxt = conv_val;
      else if (zero_mode) lane_nxt = '0;
      else                lane_nxt = prev_val;
   end
endmodule

// File: rtl/uint_vec_to_fp32.sv
module uint_vec_to_fp32
   import u2f_pkg::*;
#(
   parameter  int NUM_LANES = 16,
   localparam int VEC_W     = NUM_LANES * ELEM_W,
   localparam int LCNT_W    = $clog2(NUM_LANES + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 op_valid,
   input  logic [VEC_W-1:0]     src_vec,
   input  logic [1:0]           vlen_code,
   input  logic [NUM_LANES-1:0] lane_mask,
   input  logic                 mask_en,
   input  logic                 zero_mode,
   input  logic                 bcast_en,
   input  logic                 src_mem,
   input  logic [1:0]           emb_rm,
   input  logic [1:0]           glob_rm,
   input  logic [VEC_W-1:0]     prev_dst,
   output logic [VEC_W-1:0]     res_vec,
   output logic                 inexact
);
   if (NUM_LANES < 4 || (NUM_LANES % 4) != 0) begin : g_bad_lanes
      $error("uint_vec_to_fp32: NUM_LANES must be a positive multiple of 4");
   end

   logic [LCNT_W-1:0]    n_active;
   logic                 full_len;
   logic                 use_emb;
   logic                 bcast_mem;
   logic [1:0]           eff_rm;
   logic [VEC_W-1:0]     res_nxt;
   logic [NUM_LANES-1:0] lane_inx;

   always_comb begin
      unique case (vlen_e'(vlen_code))
         VL_QUARTER: n_active = LCNT_W'(NUM_LANES / 4);
         VL_HALF:    n_active = LCNT_W'(NUM_LANES / 2);
         default:    n_active = LCNT_W'(NUM_LANES);
      endcase
   end

   assign full_len  = (vlen_code == VL_FULL) || (vlen_code == VL_FULL_ALT);
   assign use_emb   = full_len & bcast_en & ~src_mem;
   assign bcast_mem = bcast_en & src_mem;
   assign eff_rm    = use_emb ? emb_rm : glob_rm;

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      logic [ELEM_W-1:0] lane_src;
      logic [ELEM_W-1:0] lane_fp;
      logic              lane_cvt_inx;
      logic              lane_act;

      assign lane_src = bcast_mem ? src_vec[ELEM_W-1:0] : src_vec[g*ELEM_W +: ELEM_W];
      assign lane_act = (LCNT_W'(g) < n_active);

      u2f_lane_cvt i_cvt (
         .ival    (lane_src),
         .rmode   (eff_rm),
         .fval    (lane_fp),
         .inexact (lane_cvt_inx)
      );

      u2f_lane_sel i_sel (
         .conv_val    (lane_fp),
         .prev_val    (prev_dst[g*ELEM_W +: ELEM_W]),
         .lane_active (lane_act),
         .mask_bit    (lane_mask[g]),
         .mask_en     (mask_en),
         .zero_mode   (zero_mode),
         .conv_inx    (lane_cvt_inx),
         .lane_nxt    (res_nxt[g*ELEM_W +: ELEM_W]),
         .lane_inx    (lane_inx[g])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_vec <= '0;
         inexact <= 1'b0;
      end else if (op_valid) begin
         res_vec <= res_nxt;
         inexact <= inexact | (|lane_inx);
      end
   end
endmodule

// File: rtl/u2f_checker.sv
module u2f_checker
   import u2f_pkg::*;
#(
   parameter  int NUM_LANES = 16,
   localparam int VEC_W     = NUM_LANES * ELEM_W
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 op_valid,
   input logic [1:0]           vlen_code,
   input logic [NUM_LANES-1:0] lane_mask,
   input logic                 mask_en,
   input logic                 zero_mode,
   input logic [VEC_W-1:0]     prev_dst,
   input logic [VEC_W-1:0]     res_vec,
   input logic                 inexact
);
   a_r8_quarter_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && vlen_code == 2'd0) |=> res_vec[VEC_W-1:VEC_W/4] == '0);

   a_r8_half_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && vlen_code == 2'd1) |=> res_vec[VEC_W-1:VEC_W/2] == '0);

   a_r12_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      inexact |=> inexact);

   a_r13_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> ($stable(res_vec) && $stable(inexact)));

   a_r10_merge_lane0: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && mask_en && !zero_mode && !lane_mask[0])
         |=> res_vec[ELEM_W-1:0] == $past(prev_dst[ELEM_W-1:0]));

   a_r11_all_masked_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && mask_en && zero_mode && lane_mask == '0)
         |=> (res_vec == '0 && inexact == $past(inexact)));

   a_r4_lane0_positive: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !mask_en) |=> !res_vec[ELEM_W-1]);
endmodule

bind uint_vec_to_fp32 u2f_checker #(.NUM_LANES(NUM_LANES)) i_u2f_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_valid  (op_valid),
   .vlen_code (vlen_code),
   .lane_mask (lane_mask),
   .mask_en   (mask_en),
   .zero_mode (zero_mode),
   .prev_dst  (prev_dst),
   .res_vec   (res_vec),
   .inexact   (inexact)
);

// File: tb/test_uint_vec_to_fp32.sv
module test_uint_vec_to_fp32;
   localparam int CLK_PERIOD = 10;
   localparam int NL = 16;
   localparam int VW = NL * 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          op_valid = 1'b0;
   logic [VW-1:0] src_vec = '0;
   logic [1:0]    vlen_code = 2'd2;
   logic [NL-1:0] lane_mask = '0;
   logic          mask_en = 1'b0;
   logic          zero_mode = 1'b0;
   logic          bcast_en = 1'b0;
   logic          src_mem = 1'b0;
   logic [1:0]    emb_rm = 2'd0;
   logic [1:0]    glob_rm = 2'd0;
   logic [VW-1:0] prev_dst = '0;
   logic [VW-1:0] res_vec;
   logic          inexact;

   int  n_checks = 0;
   int  n_fail = 0;
   bit  done = 1'b0;
   logic exp_flag = 1'b0;

   uint_vec_to_fp32 #(.NUM_LANES(NL)) i_uint_vec_to_fp32 (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .src_vec(src_vec),
      .vlen_code(vlen_code), .lane_mask(lane_mask), .mask_en(mask_en),
      .zero_mode(zero_mode), .bcast_en(bcast_en), .src_mem(src_mem),
      .emb_rm(emb_rm), .glob_rm(glob_rm), .prev_dst(prev_dst),
      .res_vec(res_vec), .inexact(inexact)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // arithmetic reference: truncated quotient, remainder against half an ulp
   function automatic logic [31:0] ref_lane(input logic [31:0] x, input logic [1:0] rm,
                                            output logic inx);
      longint unsigned xv, t, r, half;
      int p, sh;
      logic up;
      inx = 1'b0;
      if (x == 32'd0) return 32'd0;
      xv = 64'(x);
      p = 0;
      for (int i = 0; i < 32; i++) if (x[i]) p = i;
      if (p <= 23) return {1'b0, 8'(127 + p), 23'((xv << (23 - p)) & 64'h7FFFFF)};
      sh   = p - 23;
      t    = xv >> sh;
      r    = xv - (t << sh);
      half = 64'd1 << (sh - 1);
      inx  = (r != 0);
      case (rm)
         2'd0:    up = (r > half) || (r == half && t[0]);
         2'd2:    up = (r != 0);
         default: up = 1'b0;
      endcase
      t = t + 64'(up);
      if (t == (64'd1 << 24)) begin
         t = t >> 1;
         p = p + 1;
      end
      return {1'b0, 8'(127 + p), t[22:0]};
   endfunction

   function automatic logic [VW-1:0] ref_vec(output logic inx_o);
      logic [VW-1:0] v;
      logic [1:0]    rm;
      int            n;
      logic          li;
      logic [31:0]   lv;
      v = '0;
      inx_o = 1'b0;
      n  = (vlen_code == 2'd0) ? 4 : (vlen_code == 2'd1) ? 8 : 16;
      rm = (vlen_code >= 2'd2 && bcast_en && !src_mem) ? emb_rm : glob_rm;
      for (int j = 0; j < NL; j++) begin
         lv = (bcast_en && src_mem) ? src_vec[31:0] : src_vec[j*32 +: 32];
         if (j < n) begin
            if (!mask_en || lane_mask[j]) begin
               v[j*32 +: 32] = ref_lane(lv, rm, li);
               inx_o = inx_o | li;
            end else if (!zero_mode) begin
               v[j*32 +: 32] = prev_dst[j*32 +: 32];
            end
         end
      end
      return v;
   endfunction

   task automatic check_vec(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check_w(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // caller is at a falling edge with inputs set; returns at the next falling edge
   task automatic do_op(input string tag);
      logic [VW-1:0] ev;
      logic          oi;
      ev = ref_vec(oi);
      exp_flag = exp_flag | oi;
      op_valid = 1'b1;
      @(negedge clk);
      op_valid = 1'b0;
      check_vec(tag, res_vec, ev);
      check_w({tag, " flag"}, 32'(inexact), 32'(exp_flag));
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check_vec("R1 reset result", res_vec, '0);
      check_w("R1 reset flag", 32'(inexact), 32'd0);
      rst_n = 1'b1;
      exp_flag = 1'b0;
      @(negedge clk);
      check_vec("R1 after release", res_vec, '0);
   endtask

   function automatic logic [31:0] pick_val();
      logic [31:0] r;
      r = $urandom;
      case ($urandom % 8)
         0: return r & 32'h00FF_FFFF;
         1: return 32'h0100_0000 + (r & 32'hF);
         2: return 32'hFFFF_FFF0 | (r & 32'hF);
         3: return r & 32'h0000_00FF;
         4: return 32'h8000_0000 | (r & 32'h1FF);
         default: return r;
      endcase
   endfunction

   task automatic set_all(input logic [31:0] v);
      for (int j = 0; j < NL; j++) src_vec[j*32 +: 32] = v;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      logic [VW-1:0] held;
      do_reset();

      // R2: zero and small values exact under a rounding mode that would round up
      src_vec = '0;
      for (int j = 1; j < NL; j++) src_vec[j*32 +: 32] = 32'(j * 777 + 1);
      src_vec[32 +: 32] = 32'h00FF_FFFF;
      glob_rm = 2'd2;
      do_op("R2 exact small");
      check_w("R2 zero lane", res_vec[31:0], 32'h0000_0000);
      check_w("R2 2^24-1 lane", res_vec[63:32], 32'h4B7F_FFFF);
      check_w("R2 no flag", 32'(inexact), 32'd0);

      // R3: all four rounding modes on all-ones, ties and carries
      for (int m = 0; m < 4; m++) begin
         do_reset();
         glob_rm = 2'(m);
         set_all(32'hFFFF_FFFF);
         src_vec[32 +: 32]  = 32'h0100_0001;
         src_vec[64 +: 32]  = 32'h0100_0003;
         src_vec[96 +: 32]  = 32'h0100_0002;
         src_vec[128 +: 32] = 32'hFFFF_FF7F;
         do_op("R3 rounding modes");
         check_w("R3 all-ones", res_vec[31:0], (m == 0 || m == 2) ? 32'h4F80_0000 : 32'h4F7F_FFFF);
         check_w("R3 tie even", res_vec[63:32], (m == 2) ? 32'h4B80_0001 : 32'h4B80_0000);
      end

      // R4: top-bit inputs stay positive
      glob_rm = 2'd0;
      set_all(32'h8000_0000);
      src_vec[32 +: 32] = 32'h7FFF_FFFF;
      do_op("R4 unsigned");
      check_w("R4 0x80000000", res_vec[31:0], 32'h4F00_0000);

      // R5: override at full length with a register source, not otherwise
      set_all(32'hFFFF_FFFF);
      emb_rm = 2'd2; glob_rm = 2'd3; bcast_en = 1'b1; src_mem = 1'b0; vlen_code = 2'd2;
      do_op("R5 override used");
      check_w("R5 override used", res_vec[31:0], 32'h4F80_0000);
      vlen_code = 2'd1;
      do_op("R5 override ignored half");
      check_w("R5 override ignored half", res_vec[31:0], 32'h4F7F_FFFF);

      // R6: broadcast element 0 from memory (also R5: global mode applies)
      vlen_code = 2'd2; src_mem = 1'b1;
      for (int j = 0; j < NL; j++) src_vec[j*32 +: 32] = 32'(j + 5);
      src_vec[31:0] = 32'hFFFF_FFFF;
      do_op("R6 broadcast");
      check_w("R6 lane 9", res_vec[9*32 +: 32], 32'h4F7F_FFFF);
      bcast_en = 1'b0; src_mem = 1'b0;

      // R7 and R8: length codes and upper zeroing with a busy destination
      for (int j = 0; j < NL; j++) prev_dst[j*32 +: 32] = 32'hDEAD_0000 | 32'(j);
      for (int c = 0; c < 4; c++) begin
         vlen_code = 2'(c);
         mask_en = 1'b1; lane_mask = 16'h5555; zero_mode = 1'b0;
         do_op("R7 R8 lane count");
      end
      vlen_code = 2'd0;
      do_op("R8 quarter");
      check_vec("R8 upper zero", res_vec >> 128, '0);

      // R9 R10 R11: mask behaviour
      vlen_code = 2'd2;
      for (int j = 0; j < NL; j++) src_vec[j*32 +: 32] = 32'(j * 3 + 2);
      mask_en = 1'b0; lane_mask = 16'h0000;
      do_op("R9 mask disabled");
      check_w("R9 lane 4", res_vec[4*32 +: 32], 32'h4160_0000);
      mask_en = 1'b1; lane_mask = 16'h00F0; zero_mode = 1'b0;
      do_op("R10 merge");
      check_w("R10 lane 0 kept", res_vec[31:0], 32'hDEAD_0000);
      zero_mode = 1'b1;
      do_op("R11 zero");
      check_w("R11 lane 0 zero", res_vec[31:0], 32'h0);

      // R12: masked and inactive lanes do not raise the flag; stickiness
      do_reset();
      set_all(32'h0000_0003);
      src_vec[32 +: 32] = 32'h0100_0001;
      src_vec[15*32 +: 32] = 32'h0100_0001;
      mask_en = 1'b1; lane_mask = 16'hFFFD; zero_mode = 1'b1; vlen_code = 2'd0;
      do_op("R12 masked and inactive lanes");
      check_w("R12 no flag", 32'(inexact), 32'd0);
      lane_mask = 16'hFFFF;
      do_op("R12 set");
      check_w("R12 flag set", 32'(inexact), 32'd1);
      set_all(32'h0000_0003);
      do_op("R12 sticky");
      check_w("R12 stays", 32'(inexact), 32'd1);

      // R13: hold when idle
      held = res_vec;
      set_all(32'h1234_5678);
      repeat (3) @(negedge clk);
      check_vec("R13 hold", res_vec, held);

      // random sweep over every control combination
      for (int k = 0; k < 1500; k++) begin
         if (k % 40 == 0) do_reset();
         for (int j = 0; j < NL; j++) begin
            src_vec[j*32 +: 32]  = pick_val();
            prev_dst[j*32 +: 32] = $urandom;
         end
         vlen_code = 2'($urandom); lane_mask = 16'($urandom);
         mask_en = 1'($urandom); zero_mode = 1'($urandom);
         bcast_en = 1'($urandom); src_mem = 1'($urandom);
         emb_rm = 2'($urandom); glob_rm = 2'($urandom);
         do_op("R3 R5 R6 R9 R10 R11 R12 sweep");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule